// File: doc/BRIEF.md
# Pin Ownership and Pull-up Multiplexer

This block decides, for every pin of a 32-pin port, who drives the pin's output and output enable. The choices are the port's own I/O logic, peripheral A or peripheral B. It also produces each pin's pull-up enable. Software controls it through a small word-addressed register bus. Ownership and pull-up state change only through pairs of write-only registers: one register sets bits and the other clears them. Each pin's current state is read from a status register. A read/write select register chooses between the two peripherals.

Two module parameters fix which pins have a peripheral function at all and the ownership each pin takes at reset. A pin without a peripheral function always stays under I/O control. The pad input is delivered unchanged to the I/O logic and to both peripherals, whoever owns the output.

Register map (byte offsets on `bus_addr`):

| Offset | Register | Access |
|---|---|---|
| 0x00 | own-set (I/O takes pin) | W (reads 0) |
| 0x04 | own-clear (peripheral takes pin) | W (reads 0) |
| 0x08 | ownership status | R |
| 0x10 | pull-up off | W (reads 0) |
| 0x14 | pull-up on | W (reads 0) |
| 0x18 | pull-up status | R |
| 0x1C | peripheral select | R/W |

Top module: `pinmux_ctrl`

## Requirements
- R1: A write to 0x10 sets the pull-up status bits where the write data has 1s, and a write to 0x14 clears them. Status 1 means the pull-up is off. Status resets to all zeros, and `pad_pu` is the bitwise inverse of the status.
- R2: Pull-up writes act on a pin whatever its ownership and peripheral selection.
- R3: For a pin with a peripheral function, a write to 0x00 sets its ownership status bit and a write to 0x04 clears it. Status 1 means the I/O logic drives the pin, and 0 means the selected peripheral drives it.
- R4: For a pin whose bit in `CAP_MASK` is 0, writes to 0x00 and 0x04 are ignored, its ownership status reads 1, and its output follows the I/O drive.
- R5: After reset the ownership status equals `OWN_RST`, with every bit not set in `CAP_MASK` forced to 1.
- R6: The select register at 0x1C resets to 0 and reads back the value last written to it. Writes to it take effect in any ownership state.
- R7: When a pin's ownership bit is 1, `pad_out` and `pad_oe` come from `io_out` and `io_oe`. When it is 0, they come from peripheral A if the select bit is 0 and from peripheral B if it is 1.
- R8: `io_in`, `pa_in` and `pb_in` all equal `pad_in` in every state.
- R9: Reads of 0x00, 0x04, 0x10, 0x14 and of unmapped offsets return 0. Writes to 0x08 and 0x18 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| io_out | input | 32 | Output value from the I/O logic |
| io_oe | input | 32 | Output enable from the I/O logic |
| pa_out | input | 32 | Output value from peripheral A |
| pa_oe | input | 32 | Output enable from peripheral A |
| pb_out | input | 32 | Output value from peripheral B |
| pb_oe | input | 32 | Output enable from peripheral B |
| pad_out | output | 32 | Output value to the pads |
| pad_oe | output | 32 | Output enable to the pads |
| pad_pu | output | 32 | Pull-up enable to the pads, 1 = on |
| pad_in | input | 32 | Input value from the pads |
| io_in | output | 32 | Pad input delivered to the I/O logic |
| pa_in | output | 32 | Pad input delivered to peripheral A |
| pb_in | output | 32 | Pad input delivered to peripheral B |

## Verification
On every cycle the assertions check the effect of each set, clear and select write one cycle later, the immunity of the status registers to writes, the output mux against the stored status, and that pins without a peripheral function always follow the I/O drive. The reset values, the zero reads of write-only and unmapped offsets, the inverted pull-up sense at the pad and the input fan-out are shown by the bench's pin-by-pin sweeps. Those sweeps walk a one across every pin for each register and compare readback and pad outputs with a model built from the requirements.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
    typedef enum logic [7:0] {
        OFF_OWN_SET = 8'h00,
        OFF_OWN_CLR = 8'h04,
        OFF_OWN_STA = 8'h08,
        OFF_PU_OFF  = 8'h10,
        OFF_PU_ON   = 8'h14,
        OFF_PU_STA  = 8'h18,
        OFF_SEL     = 8'h1C
    } reg_off_e;
endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs
    import pinmux_pkg::*;
#(
    parameter int          N_PINS   = 32,
    parameter int          ADDR_W   = 8,
    parameter logic [31:0] CAP_MASK = 32'hFFFF_FF0F,
    parameter logic [31:0] OWN_RST  = 32'hFFFF_FFE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    output logic [N_PINS-1:0] own_stat,
    output logic [N_PINS-1:0] pu_stat,
    output logic [N_PINS-1:0] sel_stat
);
    localparam logic [N_PINS-1:0] CAP  = CAP_MASK[N_PINS-1:0];
    localparam logic [N_PINS-1:0] INIT = OWN_RST[N_PINS-1:0] | ~CAP;

    reg_off_e          off;
    logic [N_PINS-1:0] wcap;

    assign off  = reg_off_e'(bus_addr);
    assign wcap = bus_wdata & CAP;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_stat <= INIT;
            pu_stat  <= '0;
            sel_stat <= '0;
        end else if (bus_wr) begin
            case (off)
                OFF_OWN_SET: own_stat <= own_stat | wcap;
                OFF_OWN_CLR: own_stat <= own_stat & ~wcap;
                OFF_PU_OFF:  pu_stat  <= pu_stat | bus_wdata;
                OFF_PU_ON:   pu_stat  <= pu_stat & ~bus_wdata;
                OFF_SEL:     sel_stat <= bus_wdata;
                default:     ;
            endcase
        end
    end

    always_comb begin
        case (off)
            OFF_OWN_STA: bus_rdata = own_stat;
            OFF_PU_STA:  bus_rdata = pu_stat;
            OFF_SEL:     bus_rdata = sel_stat;
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pinmux_pinsel.sv
module pinmux_pinsel #(
    parameter bit CAPABLE = 1'b1
) (
    input  logic own,
    input  logic sel,
    input  logic io_out,
    input  logic io_oe,
    input  logic pa_out,
    input  logic pa_oe,
    input  logic pb_out,
    input  logic pb_oe,
    output logic pad_out,
    output logic pad_oe
);
    generate
        if (CAPABLE) begin : g_mux
            always_comb begin
                if (own) begin
                    pad_out = io_out;
                    pad_oe  = io_oe;
                end else if (sel) begin
                    pad_out = pb_out;
                    pad_oe  = pb_oe;
                end else begin
                    pad_out = pa_out;
                    pad_oe  = pa_oe;
                end
            end
        end else begin : g_io_only
            logic unused;
            assign unused  = own ^ sel ^ pa_out ^ pa_oe ^ pb_out ^ pb_oe;
            assign pad_out = io_out;
            assign pad_oe  = io_oe;
        end
    endgenerate
endmodule

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl #(
    parameter int          N_PINS   = 32,
    parameter int          ADDR_W   = 8,
    parameter logic [31:0] CAP_MASK = 32'hFFFF_FF0F,
    parameter logic [31:0] OWN_RST  = 32'hFFFF_FFE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    input  logic [N_PINS-1:0] io_out,
    input  logic [N_PINS-1:0] io_oe,
    input  logic [N_PINS-1:0] pa_out,
    input  logic [N_PINS-1:0] pa_oe,
    input  logic [N_PINS-1:0] pb_out,
    input  logic [N_PINS-1:0] pb_oe,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] pad_pu,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] io_in,
    output logic [N_PINS-1:0] pa_in,
    output logic [N_PINS-1:0] pb_in
);
    logic [N_PINS-1:0] own_stat;
    logic [N_PINS-1:0] pu_stat;
    logic [N_PINS-1:0] sel_stat;

    pinmux_regs #(
        .N_PINS(N_PINS), .ADDR_W(ADDR_W),
        .CAP_MASK(CAP_MASK), .OWN_RST(OWN_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .own_stat(own_stat), .pu_stat(pu_stat), .sel_stat(sel_stat)
    );

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        pinmux_pinsel #(.CAPABLE(CAP_MASK[p])) u_sel (
            .own(own_stat[p]), .sel(sel_stat[p]),
            .io_out(io_out[p]), .io_oe(io_oe[p]),
            .pa_out(pa_out[p]), .pa_oe(pa_oe[p]),
            .pb_out(pb_out[p]), .pb_oe(pb_oe[p]),
            .pad_out(pad_out[p]), .pad_oe(pad_oe[p])
        );
    end

    assign pad_pu = ~pu_stat;
    assign io_in  = pad_in;
    assign pa_in  = pad_in;
    assign pb_in  = pad_in;
endmodule

// File: rtl/pinmux_ctrl_chk.sv
module pinmux_ctrl_chk #(
    parameter int          N_PINS   = 32,
    parameter int          ADDR_W   = 8,
    parameter logic [31:0] CAP_MASK = 32'hFFFF_FF0F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N_PINS-1:0] bus_wdata,
    input logic [N_PINS-1:0] own_stat,
    input logic [N_PINS-1:0] pu_stat,
    input logic [N_PINS-1:0] sel_stat,
    input logic [N_PINS-1:0] io_out,
    input logic [N_PINS-1:0] io_oe,
    input logic [N_PINS-1:0] pa_out,
    input logic [N_PINS-1:0] pa_oe,
    input logic [N_PINS-1:0] pb_out,
    input logic [N_PINS-1:0] pb_oe,
    input logic [N_PINS-1:0] pad_out,
    input logic [N_PINS-1:0] pad_oe
);
    localparam logic [N_PINS-1:0] CAP = CAP_MASK[N_PINS-1:0];

    logic [N_PINS-1:0] exp_out, exp_oe;
    assign exp_out = (own_stat & io_out) | (~own_stat & ~sel_stat & pa_out)
                   | (~own_stat & sel_stat & pb_out);
    assign exp_oe  = (own_stat & io_oe) | (~own_stat & ~sel_stat & pa_oe)
                   | (~own_stat & sel_stat & pb_oe);

    p_pu_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h10) |=> ((pu_stat & $past(bus_wdata)) == $past(bus_wdata)));
    p_pu_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h14) |=> ((pu_stat & $past(bus_wdata)) == '0));
    p_own_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h00) |=> ((own_stat & $past(bus_wdata)) == $past(bus_wdata)));
    p_own_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h04) |=> ((own_stat & $past(bus_wdata) & CAP) == '0));
    p_noncap_io_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_out ^ io_out) | (pad_oe ^ io_oe)) & ~CAP) == '0);
    p_sel_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h1C) |=> (sel_stat == $past(bus_wdata)));
    p_mux_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out == exp_out) && (pad_oe == exp_oe));
    p_sta_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == 8'h08 || bus_addr == 8'h18))
        |=> ($stable(own_stat) && $stable(pu_stat) && $stable(sel_stat)));
endmodule

bind pinmux_ctrl pinmux_ctrl_chk #(
    .N_PINS(N_PINS), .ADDR_W(ADDR_W), .CAP_MASK(CAP_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .own_stat(own_stat), .pu_stat(pu_stat),
    .sel_stat(sel_stat), .io_out(io_out), .io_oe(io_oe),
    .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/pinmux_ctrl_bench.sv
module pinmux_ctrl_bench;
    localparam int          N   = 32;
    localparam logic [31:0] CAP = 32'hFFFF_FF0F;
    localparam logic [31:0] ORS = 32'hFFFF_FFE0;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [N-1:0] bus_wdata = '0, bus_rdata;
    logic [N-1:0] io_out = '0, io_oe = '0, pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0;
    logic [N-1:0] pad_out, pad_oe, pad_pu, pad_in = '0, io_in, pa_in, pb_in;

    int total = 0, bad = 0;
    logic [N-1:0] m_own, m_pu, m_sel;
    bit done = 0;

    always #2 clk = ~clk;

    pinmux_ctrl u_pinmux_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .io_out(io_out), .io_oe(io_oe), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_out(pb_out), .pb_oe(pb_oe), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .pad_in(pad_in), .io_in(io_in), .pa_in(pa_in), .pb_in(pb_in)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [N-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic check_mux(input string tag);
        logic [N-1:0] eo, ee;
        for (int i = 0; i < N; i++) begin
            if (m_own[i]) begin eo[i] = io_out[i]; ee[i] = io_oe[i]; end
            else if (m_sel[i]) begin eo[i] = pb_out[i]; ee[i] = pb_oe[i]; end
            else begin eo[i] = pa_out[i]; ee[i] = pa_oe[i]; end
        end
        #1;
        chk({tag, " R7 pad_out"}, pad_out, eo);
        chk({tag, " R7 pad_oe"}, pad_oe, ee);
    endtask

    task automatic check_state(input string tag);
        logic [N-1:0] d;
        rd(8'h08, d); chk({tag, " R3/R4 own status"}, d, m_own);
        rd(8'h18, d); chk({tag, " R1/R2 pu status"}, d, m_pu);
        chk({tag, " R1 pad_pu"}, pad_pu, ~m_pu);
        rd(8'h1C, d); chk({tag, " R6 select"}, d, m_sel);
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] d;
        io_out = 32'hF0F0_F0F0; io_oe = 32'hFF00_FF00;
        pa_out = 32'hCCCC_CCCC; pa_oe = 32'hAAAA_AAAA;
        pb_out = 32'h3333_3333; pb_oe = 32'h5555_5555;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_own = ORS | ~CAP; m_pu = '0; m_sel = '0;
        // R5 reset ownership, R1 and R6 reset values
        rd(8'h08, d); chk("R5 reset own status", d, ORS | ~CAP);
        check_state("reset");
        check_mux("reset");
        // R9 write-only and unmapped offsets read zero
        rd(8'h00, d); chk("R9 read own-set", d, '0);
        rd(8'h04, d); chk("R9 read own-clr", d, '0);
        rd(8'h10, d); chk("R9 read pu-off", d, '0);
        rd(8'h14, d); chk("R9 read pu-on", d, '0);
        rd(8'h0C, d); chk("R9 read unmapped", d, '0);

        // walking-one sweep: clear ownership, select, pull-up off
        for (int i = 0; i < N; i++) begin
            logic [N-1:0] b;
            b = 1 << i;
            wr(8'h04, b); m_own = m_own & ~(b & CAP);
            wr(8'h10, b); m_pu = m_pu | b;
            if (i % 3 == 0) begin wr(8'h1C, m_sel | b); m_sel = m_sel | b; end
            check_state($sformatf("sweep1 pin%0d", i));
            check_mux($sformatf("sweep1 pin%0d", i));
        end
        // R4 non-capable pins stay at 1 after a full clear
        wr(8'h04, '1); m_own = m_own & ~CAP;
        rd(8'h08, d); chk("R4 noncap own after clear-all", d, ~CAP);
        io_out = ~io_out; pa_out = ~pa_out;
        check_mux("R4 peripheral owned, inverted drives");

        // walking-one sweep: set ownership, pull-up on, select toggles
        for (int i = 0; i < N; i++) begin
            logic [N-1:0] b;
            b = 1 << i;
            wr(8'h14, b); m_pu = m_pu & ~b;
            if (i % 2 == 0) begin wr(8'h1C, m_sel ^ b); m_sel = m_sel ^ b; end
            check_mux($sformatf("sweep2 pre-own pin%0d", i));
            wr(8'h00, b); m_own = m_own | b;
            check_state($sformatf("sweep2 pin%0d", i));
            check_mux($sformatf("sweep2 pin%0d", i));
        end

        // R9 status registers ignore writes
        wr(8'h04, 32'h0000_FF0F); m_own = m_own & ~(32'h0000_FF0F & CAP);
        wr(8'h10, 32'h1234_5678); m_pu = m_pu | 32'h1234_5678;
        wr(8'h08, 32'h0000_0000);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        check_state("R9 after status writes");
        check_mux("R9 after status writes");

        // R8 input fan-out under several patterns
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            pad_in = 32'h9E37_79B9 * (k + 1);
            #1;
            chk("R8 io_in", io_in, pad_in);
            chk("R8 pa_in", pa_in, pad_in);
            chk("R8 pb_in", pb_in, pad_in);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule